// File: doc/BRIEF.md
# Coherent Diagnostic Register Shadow

This block keeps a bank of 16-bit monitoring values (received optical power, temperature, supply voltage and similar) in a shadow store and serves them to an external host one byte at a time. A local update agent writes whole 16-bit values in a single cycle. A byte-serial two-wire slave engine, which is outside this block and has already matched the diagnostic device address, hands the block decoded events: a transaction start that carries a byte offset, a strobe for each byte read, and a stop.

The host may read the two bytes of a field in one sequential read, high byte first. In that case it always gets both bytes from the same value. Reading the high byte copies the whole field into a holding register and locks the field. The low byte that follows comes from that copy. Local updates to a locked field go into a one-entry pending slot for that field. The pending value lands in the store when the lock is released, which happens on the low-byte read, on a stop, or on a new start. Start and stop take precedence over a read strobe in the same cycle, and that strobe is ignored.

Top module: `diag_coherent_shadow`

## Requirements
- R1: Field k sits at byte offsets FIELD_BASE+2k (high byte) and FIELD_BASE+2k+1 (low byte). With the default base of 96, field 4 is the receive power at offsets 104 and 105.
- R2: A read strobe produces `rd_valid_o` high together with the byte on `rd_data_o` in the following cycle. `rd_valid_o` is low in every cycle that does not follow a read strobe.
- R3: A start loads the byte pointer from `host_addr_i`. Each read returns the byte at the pointer and then increments it by one, wrapping from 2^ADDR_W-1 to 0.
- R4: A read of an offset outside the field region returns FILL_BYTE (0x00 by default).
- R5: A read of a high byte snapshots the whole field. The low-byte read that follows returns the snapshot's low byte, even if the field was updated in between.
- R6: An update to a field is deferred to that field's pending slot in two cases: when the field's high byte is being read in the same cycle, and while the field is locked and the lock is not released in that cycle. The visible value does not change.
- R7: A pending value is committed when the lock on its field is released by the low-byte read, by a stop, or by a new start. Later reads return the committed value.
- R8: A second update to a locked field replaces the pending value, so only the newest value is committed.
- R9: An update that arrives in the same cycle as a lock release takes effect directly and wins over any older pending value.
- R10: A read that begins on a low byte, with no high-byte read of the field just before it, returns the current stored byte and does not lock the field. An update right after it takes effect at once.
- R11: An update to an unlocked field is visible to any read that starts in the next cycle or later.
- R12: Updates are ignored when their address is odd or lies outside the field region.
- R13: Reset sets every stored value, the holding register and all pending slots to zero, so no pre-reset value appears after reset, not even after a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid_i | input | 1 | Single-cycle update strobe from the local agent |
| upd_addr_i | input | ADDR_W | Byte offset of the field's high byte (must be even) |
| upd_data_i | input | 16 | New 16-bit field value |
| host_start_i | input | 1 | Transaction start; loads the byte pointer |
| host_addr_i | input | ADDR_W | Starting byte offset for the transaction |
| host_rd_i | input | 1 | Read strobe for one byte |
| host_stop_i | input | 1 | Transaction stop |
| rd_data_o | output | 8 | Byte returned for the previous read strobe |
| rd_valid_o | output | 1 | High for one cycle after each accepted read strobe |

## Verification
The bench builds the block with ADDR_W 8, FIELD_BASE 248, NUM_FIELDS 4 and FILL_BYTE 0xA5. With these values the field region ends at the very top of the address space, so a read of the last low byte is followed directly by a wrap to offset 0. The non-zero fill byte also keeps unmapped reads distinct from reset zeros. Because there are only four fields, random updates and random read starts often hit the field that is locked, which exercises deferral, overwrite of the pending slot, and commits that coincide with a release.

// File: rtl/diag_shadow_pkg.sv
package diag_shadow_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WORD_W = 2 * BYTE_W;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/diag_field_slot.sv
module diag_field_slot
   import diag_shadow_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en_i,
   input  word_t wr_data_i,
   input  logic  defer_i,
   input  logic  rel_i,
   output word_t value_o
);
   word_t shadow_q;
   word_t pend_q;
   logic  pend_v_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         pend_q   <= '0;
         pend_v_q <= 1'b0;
      end else if (wr_en_i && defer_i) begin
         pend_q   <= wr_data_i;
         pend_v_q <= 1'b1;
      end else if (wr_en_i) begin
         shadow_q <= wr_data_i;
         pend_v_q <= 1'b0;
      end else if (rel_i && pend_v_q) begin
         shadow_q <= pend_q;
         pend_v_q <= 1'b0;
      end
   end

   assign value_o = shadow_q;

   // R6: a locked field keeps its visible value
   a_r6_defer_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
      defer_i |=> shadow_q == $past(shadow_q));

   // R7: release with a pending value and no fresh update commits it
   a_r7_commit_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_i && pend_v_q && !wr_en_i) |=> shadow_q == $past(pend_q));
endmodule

// File: rtl/diag_read_port.sv
module diag_read_port
   import diag_shadow_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned FIELD_BASE = 96,
   parameter int unsigned NUM_FIELDS = 8,
   parameter int unsigned IDX_W      = 3,
   parameter logic [7:0]  FILL_BYTE  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              rd_i,
   input  logic              stop_i,
   input  word_t             field_i [NUM_FIELDS],
   output byte_t             rd_data_o,
   output logic              rd_valid_o,
   output logic [NUM_FIELDS-1:0] defer_o,
   output logic [NUM_FIELDS-1:0] rel_o
);
   localparam int unsigned SPAN     = 2 * NUM_FIELDS;
   localparam logic [ADDR_W:0]   SPAN_X = SPAN[ADDR_W:0];
   localparam logic [ADDR_W-1:0] BASE_A = FIELD_BASE[ADDR_W-1:0];

   logic [ADDR_W-1:0] ptr_q;
   logic              lock_v_q;
   logic [IDX_W-1:0]  lock_idx_q;
   word_t             hold_q;

   logic [ADDR_W-1:0] offs;
   logic              in_reg;
   logic [IDX_W-1:0]  idx;
   word_t             cur;
   logic              act_rd;
   logic              take_msb;
   logic              take_hold;
   logic              rel_any;

   assign offs      = ptr_q - BASE_A;
   assign in_reg    = {1'b0, offs} < SPAN_X;
   assign idx       = offs[IDX_W:1];
   assign cur       = field_i[idx];
   assign act_rd    = rd_i && !start_i && !stop_i;
   assign take_msb  = act_rd && in_reg && !offs[0];
   assign take_hold = act_rd && in_reg && offs[0] && lock_v_q && (idx == lock_idx_q);
   assign rel_any   = lock_v_q && (start_i || stop_i || take_hold);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q      <= '0;
         lock_v_q   <= 1'b0;
         lock_idx_q <= '0;
         hold_q     <= '0;
         rd_data_o  <= '0;
         rd_valid_o <= 1'b0;
      end else begin
         rd_valid_o <= act_rd;
         if (start_i)
            ptr_q <= start_addr_i;
         else if (act_rd)
            ptr_q <= ptr_q + 1'b1;
         if (rel_any)
            lock_v_q <= 1'b0;
         if (take_msb) begin
            lock_v_q   <= 1'b1;
            lock_idx_q <= idx;
            hold_q     <= cur;
         end
         if (act_rd) begin
            if (take_msb)       rd_data_o <= cur[15:8];
            else if (take_hold) rd_data_o <= hold_q[7:0];
            else if (in_reg)    rd_data_o <= cur[7:0];
            else                rd_data_o <= FILL_BYTE;
         end
      end
   end

   for (genvar j = 0; j < NUM_FIELDS; j++) begin : g_ctl
      assign defer_o[j] = (lock_v_q && lock_idx_q == IDX_W'(j) && !rel_any)
                        || (take_msb && idx == IDX_W'(j));
      assign rel_o[j]   = rel_any && lock_idx_q == IDX_W'(j);
   end

   // R3: pointer steps by one per accepted read, modulo the address space
   a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      act_rd |=> ptr_q == $past(ptr_q) + 1'b1);

   // R2: valid only in the cycle after a read strobe
   a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> $past(rd_i));

   // R5: snapshot stays frozen while the field is locked
   a_r5_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      lock_v_q |=> $stable(hold_q));

   // R6: at most one field is being held back at any time
   a_r6_single_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(defer_o));
endmodule

// File: rtl/diag_coherent_shadow.sv
module diag_coherent_shadow
   import diag_shadow_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned FIELD_BASE = 96,
   parameter int unsigned NUM_FIELDS = 8,
   parameter logic [7:0]  FILL_BYTE  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_valid_i,
   input  logic [ADDR_W-1:0] upd_addr_i,
   input  logic [15:0]       upd_data_i,
   input  logic              host_start_i,
   input  logic [ADDR_W-1:0] host_addr_i,
   input  logic              host_rd_i,
   input  logic              host_stop_i,
   output logic [7:0]        rd_data_o,
   output logic              rd_valid_o
);
   localparam int unsigned IDX_W  = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1;
   localparam int unsigned SPAN   = 2 * NUM_FIELDS;
   localparam logic [ADDR_W:0]   SPAN_X = SPAN[ADDR_W:0];
   localparam logic [ADDR_W-1:0] BASE_A = FIELD_BASE[ADDR_W-1:0];

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr_w
      $error("ADDR_W must lie in 2..16");
   end
   if (NUM_FIELDS < 1) begin : g_bad_count
      $error("NUM_FIELDS must be at least 1");
   end
   if (FIELD_BASE % 2 != 0) begin : g_bad_align
      $error("FIELD_BASE must be even");
   end
   if (FIELD_BASE + SPAN > (1 << ADDR_W)) begin : g_bad_span
      $error("field region exceeds the address space");
   end
   if (IDX_W >= ADDR_W) begin : g_bad_idx
      $error("too many fields for ADDR_W");
   end

   logic [ADDR_W-1:0]     u_offs;
   logic                  u_ok;
   logic [IDX_W-1:0]      u_idx;
   logic [NUM_FIELDS-1:0] wr_en;
   logic [NUM_FIELDS-1:0] defer;
   logic [NUM_FIELDS-1:0] rel;
   word_t                 vals [NUM_FIELDS];

   assign u_offs = upd_addr_i - BASE_A;
   assign u_ok   = upd_valid_i && !u_offs[0] && ({1'b0, u_offs} < SPAN_X);
   assign u_idx  = u_offs[IDX_W:1];

   for (genvar j = 0; j < NUM_FIELDS; j++) begin : g_slot
      assign wr_en[j] = u_ok && (u_idx == IDX_W'(j));
      diag_field_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en_i   (wr_en[j]),
         .wr_data_i (upd_data_i),
         .defer_i   (defer[j]),
         .rel_i     (rel[j]),
         .value_o   (vals[j])
      );
   end

   diag_read_port #(
      .ADDR_W     (ADDR_W),
      .FIELD_BASE (FIELD_BASE),
      .NUM_FIELDS (NUM_FIELDS),
      .IDX_W      (IDX_W),
      .FILL_BYTE  (FILL_BYTE)
   ) u_rport (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (host_start_i),
      .start_addr_i (host_addr_i),
      .rd_i         (host_rd_i),
      .stop_i       (host_stop_i),
      .field_i      (vals),
      .rd_data_o    (rd_data_o),
      .rd_valid_o   (rd_valid_o),
      .defer_o      (defer),
      .rel_o        (rel)
   );

   // R12: a misaligned or out-of-region update reaches no slot
   a_r12_bad_update_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid_i && upd_addr_i[0]) |-> wr_en == '0);
endmodule

// File: tb/diag_coherent_shadow_tb.sv
`timescale 1ns/1ps
module diag_coherent_shadow_tb;
   localparam int unsigned AW   = 8;
   localparam int unsigned BASE = 248;
   localparam int unsigned NF   = 4;
   localparam logic [7:0]  FILL = 8'hA5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_valid = 1'b0;
   logic [7:0]  upd_addr = '0;
   logic [15:0] upd_data = '0;
   logic        h_start = 1'b0;
   logic [7:0]  h_addr = '0;
   logic        h_rd = 1'b0;
   logic        h_stop = 1'b0;
   logic [7:0]  rd_data;
   logic        rd_valid;

   int checks = 0;
   int errors = 0;

   // reference model state
   logic [15:0] m_sh [NF];
   logic [15:0] m_pd [NF];
   bit          m_pv [NF];
   bit          m_lock;
   int          m_lidx;
   logic [15:0] m_hold;
   logic [7:0]  m_ptr;

   always #10 clk = ~clk;

   diag_coherent_shadow #(
      .ADDR_W(AW), .FIELD_BASE(BASE), .NUM_FIELDS(NF), .FILL_BYTE(FILL)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .upd_valid_i(upd_valid), .upd_addr_i(upd_addr), .upd_data_i(upd_data),
      .host_start_i(h_start), .host_addr_i(h_addr), .host_rd_i(h_rd),
      .host_stop_i(h_stop), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
   );

   task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void model_reset();
      for (int i = 0; i < NF; i++) begin
         m_sh[i] = '0; m_pd[i] = '0; m_pv[i] = 1'b0;
      end
      m_lock = 1'b0; m_lidx = 0; m_hold = '0; m_ptr = '0;
   endfunction

   // requirement-level model of one clock cycle; returns the expected byte
   function automatic logic [7:0] model_step(bit st, logic [7:0] sa, bit rd, bit sp,
                                             bit uv, logic [7:0] ua, logic [15:0] ud);
      logic [7:0] exp = FILL;
      bit rel = 1'b0;
      int rel_idx = m_lidx;
      int off = (int'(m_ptr) - int'(BASE) + 256) % 256;
      int uoff = (int'(ua) - int'(BASE) + 256) % 256;
      if (st || sp) begin
         if (m_lock) begin rel = 1'b1; m_lock = 1'b0; end
         if (st) m_ptr = sa;
      end else if (rd) begin
         if (off < 2*NF && off % 2 == 0) begin
            exp = m_sh[off/2][15:8];
            m_hold = m_sh[off/2];
            m_lock = 1'b1; m_lidx = off/2;
         end else if (off < 2*NF && m_lock && m_lidx == off/2) begin
            exp = m_hold[7:0];
            rel = 1'b1; m_lock = 1'b0;
         end else if (off < 2*NF) begin
            exp = m_sh[off/2][7:0];
         end
         m_ptr = m_ptr + 8'd1;
      end
      if (rel && m_pv[rel_idx]) begin
         m_sh[rel_idx] = m_pd[rel_idx];
         m_pv[rel_idx] = 1'b0;
      end
      if (uv && uoff < 2*NF && uoff % 2 == 0) begin
         if (m_lock && m_lidx == uoff/2) begin
            m_pd[uoff/2] = ud; m_pv[uoff/2] = 1'b1;
         end else begin
            m_sh[uoff/2] = ud; m_pv[uoff/2] = 1'b0;
         end
      end
      return exp;
   endfunction

   task automatic op(input bit st, input logic [7:0] sa, input bit rd, input bit sp,
                     input bit uv, input logic [7:0] ua, input logic [15:0] ud, input string req);
      logic [7:0] exp;
      h_start = st; h_addr = sa; h_rd = rd; h_stop = sp;
      upd_valid = uv; upd_addr = ua; upd_data = ud;
      exp = model_step(st, sa, rd, sp, uv, ua, ud);
      @(posedge clk); #2;
      if (rd && !st && !sp) begin
         check(rd_valid === 1'b1, req, {15'd0, rd_valid}, 16'd1);
         check(rd_data === exp, req, {8'd0, rd_data}, {8'd0, exp});
      end else begin
         check(rd_valid === 1'b0, {req, " R2 idle"}, {15'd0, rd_valid}, 16'd0);
      end
      h_start = 0; h_rd = 0; h_stop = 0; upd_valid = 0;
   endtask

   task automatic start(input logic [7:0] a, input string req); op(1, a, 0, 0, 0, 0, 0, req); endtask
   task automatic rd(input string req);                         op(0, 0, 1, 0, 0, 0, 0, req); endtask
   task automatic stop(input string req);                       op(0, 0, 0, 1, 0, 0, 0, req); endtask
   task automatic upd(input logic [7:0] a, input logic [15:0] d, input string req);
      op(0, 0, 0, 0, 1, a, d, req);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_reset();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20211));
      model_reset();
      do_reset();
      check(rd_valid === 1'b0, "R13 reset valid", {15'd0, rd_valid}, 16'd0);

      // R13 and R1: all fields read zero after reset
      start(8'd248, "R13");
      for (int i = 0; i < 8; i++) rd("R13 zero after reset");
      stop("R13");

      // R11 and R1: unlocked updates, byte order high then low
      upd(8'd248, 16'h1234, "R11");
      start(8'd248, "R1");
      rd("R1 high byte at even offset");
      rd("R1 low byte at odd offset");
      upd(8'd250, 16'hABCD, "R11");
      rd("R11 next field high");
      rd("R11 next field low");
      stop("R1");

      // R5 and R6: update between high and low read is held back
      start(8'd252, "R5");
      upd(8'd252, 16'h1111, "R11");
      rd("R5 high byte snapshot");
      upd(8'd252, 16'h2222, "R6 deferred");
      rd("R5 low byte from snapshot");
      start(8'd252, "R7");
      rd("R7 committed after low-byte release");
      rd("R7 committed low");

      // R8 and R7 via stop, R3 and R4 wrap into unmapped space
      start(8'd254, "R8");
      rd("R8 high");
      upd(8'd254, 16'h3333, "R8 first");
      upd(8'd254, 16'h4444, "R8 second");
      stop("R7 stop release");
      start(8'd254, "R8");
      rd("R8 newest committed high");
      rd("R8 newest committed low");
      rd("R3 wrap to 0 and R4 fill");
      rd("R4 fill at 1");
      stop("R3");

      // R9: update in the release cycle wins; R6: update in lock cycle
      start(8'd248, "R9");
      rd("R9 high");
      op(0, 0, 1, 0, 1, 8'd248, 16'h5555, "R9 low from snapshot");
      start(8'd248, "R9");
      rd("R9 direct high");
      op(0, 0, 1, 0, 0, 0, 0, "R9 direct low");
      start(8'd248, "R6");
      op(0, 0, 1, 0, 1, 8'd248, 16'h6666, "R6 update in lock cycle");
      rd("R6 low still old");
      start(8'd248, "R7");
      rd("R7 commit high");
      stop("R7");

      // R10: low-byte start neither locks nor defers
      start(8'd249, "R10");
      rd("R10 current low");
      upd(8'd248, 16'h7777, "R10 immediate");
      start(8'd248, "R10");
      rd("R10 update visible high");
      rd("R10 update visible low");
      stop("R10");

      // R12: odd or outside addresses are ignored
      upd(8'd249, 16'h9999, "R12 odd");
      upd(8'd100, 16'h8888, "R12 unmapped");
      upd(8'd0, 16'h8888, "R12 unmapped zero");
      start(8'd248, "R12");
      rd("R12 field unchanged high");
      rd("R12 field unchanged low");
      stop("R12");

      // R7 via new start
      start(8'd250, "R7");
      rd("R7 lock field 1");
      upd(8'd250, 16'hBEEF, "R7 deferred");
      start(8'd250, "R7 start release");
      rd("R7 start-commit high");
      rd("R7 start-commit low");
      stop("R7");

      // R13: reset discards pending and stored values
      start(8'd252, "R13");
      rd("R13 lock before reset");
      upd(8'd252, 16'hCAFE, "R13 pending before reset");
      do_reset();
      stop("R13 stop after reset");
      start(8'd248, "R13");
      for (int i = 0; i < 8; i++) rd("R13 zero after second reset");
      stop("R13");

      // random mix
      for (int n = 0; n < 3000; n++) begin
         int r = $urandom % 100;
         bit st = (r < 15);
         bit sp = (r >= 15 && r < 22);
         bit rr = (r >= 22 && r < 75) || (r >= 95);
         bit uv = ($urandom % 100) < 35;
         logic [7:0] sa = (($urandom % 4) == 0) ? 8'($urandom % 256) : 8'(BASE + $urandom % 8);
         logic [7:0] ua = (($urandom % 10) == 0) ? 8'($urandom % 256) : 8'(BASE + 2 * ($urandom % NF));
         logic [15:0] ud = 16'($urandom);
         op(st, sa, rr, sp, uv, ua, ud, "R5 R6 R7 R8 R9 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule